// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

This block is a shared lock for a fixed number of requesters. Each requester gets a place in line. A requester raises a one-cycle acquire strobe. In that same cycle the unit hands it the current value of a request counter as its ticket and moves the counter on by one, so no two requesters can ever draw the same ticket. A serving counter names the ticket that currently owns the lock. A requester whose stored ticket equals the serving counter is granted the lock. The owner gives the lock up with a one-cycle release strobe, which advances the serving counter and passes the lock to the next ticket.

Service is strictly first come, first served, so no requester can starve. A requester that releases and then acquires again goes to the back of the line, behind every ticket drawn before it. Acquires that arrive in the same cycle are numbered by requester index, lowest index first. Both counters wrap modulo their width. The width must leave room for every requester to hold a ticket at once, so equality between a ticket and the serving counter stays unambiguous.

Two kinds of misuse are caught, ignored and flagged: a release from a requester that does not hold the grant, and an acquire from a requester that already holds a ticket.

Top module: `tkt_lock_unit`

## Requirements
- R1: After reset both counters are zero, every grant is low, both error flags are low and every ticket output reads 0.
- R2: An acquire from a requester without a ticket stores the current request count as that requester's ticket on `tkt_o` after the clock edge that samples the acquire, and the request count advances by one.
- R3: Acquires sampled on the same edge receive consecutive tickets in ascending requester index (bit 0 of `acq_i` first).
- R4: A grant is registered: it rises on the clock edge after the one on which the holder's ticket starts to equal the serving count. On an idle unit, an acquire on edge k is granted from edge k+1.
- R5: At most one grant is high in any cycle, and grants are issued in ascending ticket order (first come, first served).
- R6: A release from the requester holding the grant advances the serving count by one and drops that grant on the sampling edge. The next ticket in line is granted one edge later.
- R7: A release from a requester that does not hold the grant leaves the serving count and all grants unchanged, and `rel_err_o` is high for exactly the one cycle after the sampling edge.
- R8: An acquire from a requester that already holds a ticket (waiting or granted) is ignored: its ticket and the request count are unchanged, and `acq_err_o` is high for exactly the one cycle after the sampling edge.
- R9: Both counters wrap modulo 2^TKT_W. Service order continues unbroken across the wrap, and the number of outstanding tickets never exceeds N_REQ.
- R10: A requester that releases and then acquires again is given a ticket after every ticket already drawn, and is served after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_i | input | N_REQ | One-cycle acquire strobe per requester |
| rel_i | input | N_REQ | One-cycle release strobe per requester |
| tkt_o | output | N_REQ*TKT_W | Ticket held by each requester; requester i uses bits [i*TKT_W +: TKT_W] |
| grant_o | output | N_REQ | Lock owned, per requester |
| acq_err_o | output | 1 | Pulse: acquire from a requester that already holds a ticket |
| rel_err_o | output | 1 | Pulse: release from a requester that does not hold the grant |

## Verification
Some properties are checked on every cycle. At most one grant is high. The number of outstanding tickets never exceeds the requester count. The serving count only ever steps by one. A grant is only ever held for the ticket the serving count names. A held ticket never changes. A bad release never moves the serving count. Other behaviour can only be shown by the bench's scenarios. These are the exact ticket values handed out under simultaneous acquires, the first-come order of grants over many hand-offs and across the counter wrap, the two-edge hand-off latency, and the single-cycle error pulses. A scoreboard records the expected grant order as each acquire is accepted and compares it against each new grant.

// File: rtl/tkt_pkg.sv
package tkt_pkg;
   // smallest counter width that keeps N outstanding tickets distinct
   // and lets the outstanding count N itself be represented
   function automatic int f_min_tkt_w(input int n_req);
      return $clog2(n_req + 1);
   endfunction
endpackage

// File: rtl/tkt_dispenser.sv
module tkt_dispenser #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_REQ-1:0]         take_i,
   output logic [N_REQ*TKT_W-1:0]   next_tkt_o,
   output logic [TKT_W-1:0]         req_cnt_o
);
   logic [TKT_W-1:0] req_cnt_q;
   logic [TKT_W-1:0] req_cnt_d;

   // fetch-and-increment, lowest index drawn first
   always_comb begin
      logic [TKT_W-1:0] run;
      run = req_cnt_q;
      next_tkt_o = '0;
      for (int i = 0; i < N_REQ; i++) begin
         next_tkt_o[i*TKT_W +: TKT_W] = run;
         if (take_i[i]) run = run + TKT_W'(1);
      end
      req_cnt_d = run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_cnt_q <= '0;
      else        req_cnt_q <= req_cnt_d;
   end

   assign req_cnt_o = req_cnt_q;

   AST_REQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i == '0) |=> $stable(req_cnt_q)) else $error("req count moved idle"); // R2
endmodule

// File: rtl/tkt_server.sv
module tkt_server #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] rel_i,
   input  logic [N_REQ-1:0] grant_i,
   output logic [N_REQ-1:0] drop_o,
   output logic [TKT_W-1:0] srv_cnt_o,
   output logic             rel_err_o
);
   logic [TKT_W-1:0] srv_cnt_q;
   logic             err_q;
   logic [N_REQ-1:0] bad_rel;

   assign drop_o  = rel_i & grant_i;
   assign bad_rel = rel_i & ~grant_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srv_cnt_q <= '0;
         err_q     <= 1'b0;
      end else begin
         if (|drop_o) srv_cnt_q <= srv_cnt_q + TKT_W'(1);
         err_q <= |bad_rel;
      end
   end

   assign srv_cnt_o = srv_cnt_q;
   assign rel_err_o = err_q;

   AST_SERVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(srv_cnt_q) |-> (srv_cnt_q == $past(srv_cnt_q) + TKT_W'(1))) else $error("serve jump"); // R6
   AST_BAD_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((rel_i != '0) && ((rel_i & grant_i) == '0)) |=> $stable(srv_cnt_q)) else $error("bad release moved"); // R7
endmodule

// File: rtl/tkt_slot.sv
module tkt_slot #(
   parameter int TKT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [TKT_W-1:0] new_tkt_i,
   input  logic             drop_i,
   input  logic [TKT_W-1:0] srv_i,
   output logic             held_o,
   output logic [TKT_W-1:0] tkt_o,
   output logic             grant_o
);
   logic             held_q;
   logic             grant_q;
   logic [TKT_W-1:0] tkt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         grant_q <= 1'b0;
         tkt_q   <= '0;
      end else begin
         if (drop_i)      held_q <= 1'b0;
         else if (take_i) held_q <= 1'b1;
         if (take_i) tkt_q <= new_tkt_i;
         grant_q <= held_q && (tkt_q == srv_i) && !drop_i;
      end
   end

   assign held_o  = held_q;
   assign tkt_o   = tkt_q;
   assign grant_o = grant_q;

   AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> (held_q && tkt_q == srv_i)) else $error("grant without match"); // R4
   AST_TKT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && $past(held_q)) |-> $stable(tkt_q)) else $error("held ticket changed"); // R8
endmodule

// File: rtl/tkt_lock_unit.sv
module tkt_lock_unit #(
   parameter int N_REQ = 4,
   parameter int TKT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_REQ-1:0]       acq_i,
   input  logic [N_REQ-1:0]       rel_i,
   output logic [N_REQ*TKT_W-1:0] tkt_o,
   output logic [N_REQ-1:0]       grant_o,
   output logic                   acq_err_o,
   output logic                   rel_err_o
);
   import tkt_pkg::*;
   localparam int MIN_W = f_min_tkt_w(N_REQ);

   initial begin
      if (N_REQ < 1)     $error("N_REQ must be at least 1");
      if (TKT_W < MIN_W) $error("TKT_W too narrow for N_REQ outstanding tickets");
   end

   logic [N_REQ-1:0]       held;
   logic [N_REQ-1:0]       take;
   logic [N_REQ-1:0]       drop;
   logic [N_REQ*TKT_W-1:0] next_tkt;
   logic [TKT_W-1:0]       req_cnt;
   logic [TKT_W-1:0]       srv_cnt;
   logic                   acq_err_q;

   assign take = acq_i & ~held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acq_err_q <= 1'b0;
      else        acq_err_q <= |(acq_i & held);
   end
   assign acq_err_o = acq_err_q;

   tkt_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_disp (
      .clk(clk), .rst_n(rst_n), .take_i(take),
      .next_tkt_o(next_tkt), .req_cnt_o(req_cnt)
   );

   tkt_server #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_srv (
      .clk(clk), .rst_n(rst_n), .rel_i(rel_i), .grant_i(grant_o),
      .drop_o(drop), .srv_cnt_o(srv_cnt), .rel_err_o(rel_err_o)
   );

   for (genvar g = 0; g < N_REQ; g++) begin : g_slot
      tkt_slot #(.TKT_W(TKT_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .take_i(take[g]), .new_tkt_i(next_tkt[g*TKT_W +: TKT_W]),
         .drop_i(drop[g]), .srv_i(srv_cnt),
         .held_o(held[g]), .tkt_o(tkt_o[g*TKT_W +: TKT_W]), .grant_o(grant_o[g])
      );
   end

   AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)) else $error("two holders"); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (TKT_W'(req_cnt - srv_cnt) <= TKT_W'(N_REQ))) else $error("too many tickets"); // R9
   AST_OUTSTANDING_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (TKT_W'(req_cnt - srv_cnt) == TKT_W'($countones(held)))) else $error("ticket count drift"); // R2
endmodule

// File: tb/tkt_lock_unit_test.sv
module tkt_lock_unit_test;
   localparam int N = 4;
   localparam int W = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   acq_i = '0;
   logic [N-1:0]   rel_i = '0;
   logic [N*W-1:0] tkt_o;
   logic [N-1:0]   grant_o;
   logic           acq_err_o;
   logic           rel_err_o;

   int checks = 0;
   int fails  = 0;
   int exp_req = 0;
   int exp_q[$];
   logic [N-1:0] prev_g = '0;

   always #5 clk = ~clk;

   tkt_lock_unit #(.N_REQ(N), .TKT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
      .tkt_o(tkt_o), .grant_o(grant_o), .acq_err_o(acq_err_o), .rel_err_o(rel_err_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int tkt_of(input int i);
      return int'(tkt_o[i*W +: W]);
   endfunction

   // driver: acquire strobes; accepted acquires push expected grant order
   task automatic do_acquire(input logic [N-1:0] m);
      acq_i = m;
      @(negedge clk);
      acq_i = '0;
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            chk(tkt_of(i) == exp_req % (1 << W), "R2/R3/R9 ticket", tkt_of(i), exp_req % (1 << W));
            exp_q.push_back(i);
            exp_req++;
         end
      end
   endtask

   task automatic do_release(input int idx);
      rel_i = '0;
      rel_i[idx] = 1'b1;
      @(negedge clk);
      rel_i = '0;
      chk(grant_o == '0, "R6 grant dropped on release", int'(grant_o), 0);
   endtask

   task automatic wait_grant(output int idx);
      idx = -1;
      for (int k = 0; k < 20 && idx < 0; k++) begin
         for (int i = 0; i < N; i++) if (grant_o[i]) idx = i;
         if (idx < 0) @(negedge clk);
      end
      chk(idx >= 0, "R5 grant arrives", idx, 0);
   endtask

   // monitor: each new grant must be the next expected requester
   always @(negedge clk) begin
      if (rst_n && grant_o != prev_g && grant_o != '0) begin
         chk($countones(grant_o) == 1, "R5 single grant", $countones(grant_o), 1);
         if (exp_q.size() == 0) chk(1'b0, "R5 unexpected grant", int'(grant_o), 0);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(grant_o == (N'(1) << e), "R5 FIFO grant order", int'(grant_o), 1 << e);
         end
      end
      prev_g = grant_o;
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      int h;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(grant_o == '0, "R1 grants low", int'(grant_o), 0);
      chk(tkt_o == '0, "R1 tickets zero", int'(tkt_o), 0);
      chk(!acq_err_o && !rel_err_o, "R1 errors low", int'({acq_err_o, rel_err_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R4: single acquire, grant one edge later
      do_acquire(4'b0100);
      chk(grant_o == '0, "R4 no grant yet", int'(grant_o), 0);
      @(negedge clk);
      chk(grant_o == 4'b0100, "R4 grant after one edge", int'(grant_o), 4);

      // R3: simultaneous acquires numbered by index
      do_acquire(4'b1011);
      chk(tkt_of(0) == 1 && tkt_of(1) == 2 && tkt_of(3) == 3, "R3 ordered tickets",
          tkt_of(0) * 100 + tkt_of(1) * 10 + tkt_of(3), 123);

      // R8: holder acquires again
      acq_i = 4'b0100;
      @(negedge clk);
      acq_i = '0;
      chk(acq_err_o == 1'b1, "R8 acq_err pulse", int'(acq_err_o), 1);
      chk(tkt_of(2) == 0, "R8 ticket unchanged", tkt_of(2), 0);
      @(negedge clk);
      chk(acq_err_o == 1'b0, "R8 acq_err one cycle", int'(acq_err_o), 0);

      // R7: release by non-holder
      rel_i = 4'b0010;
      @(negedge clk);
      rel_i = '0;
      chk(rel_err_o == 1'b1, "R7 rel_err pulse", int'(rel_err_o), 1);
      chk(grant_o == 4'b0100, "R7 grant unchanged", int'(grant_o), 4);
      @(negedge clk);
      chk(rel_err_o == 1'b0, "R7 rel_err one cycle", int'(rel_err_o), 0);
      chk(grant_o == 4'b0100, "R7 serving unchanged", int'(grant_o), 4);

      // R6, R10: holder releases and re-queues behind earlier tickets
      do_release(2);
      do_acquire(4'b0100);
      chk(grant_o == 4'b0001, "R6 next ticket granted", int'(grant_o), 1);
      chk(tkt_of(2) == 4, "R10 requeue ticket", tkt_of(2), 4);

      // R9: many hand-offs, counters wrap
      for (int k = 0; k < 12; k++) begin
         wait_grant(h);
         do_release(h);
         do_acquire(N'(1) << h);
      end
      chk(exp_req > (1 << W), "R9 wrapped", exp_req, 1 << W);
      chk(!acq_err_o && !rel_err_o, "R9 no errors in legal use", int'({acq_err_o, rel_err_o}), 0);
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule